// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines for a small 8-bit processor and decides which one the processor should take next. The sources are split into six groups of three. Software gives each group one of four priority levels. Each source has a sticky pending flag and its own enable bit, and a global enable gates all vector delivery. The controller offers the winning source index to the processor and waits for an acknowledge. It then records that the level is in service, so that only a strictly higher level can interrupt the handler. A return pulse ends the innermost service level.

While the system is in a low-power mode, the block also raises a wake request. Only sources marked wake-capable by a build-time mask can do this. Request lines are still captured into the pending flags during sleep, so the event that caused the wake is delivered once the processor runs again.

Software reaches four registers through a 2-bit address:
- Address 0 holds the per-source enables.
- Address 1 holds the group levels.
- Address 2 reads the pending flags. Writing it clears flags, one bit per source (write 1 to clear).
- Address 3, bit 0, holds the global enable.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_valid` is 0 and `wake_req` is 0.
- R2: A high level on `irq_req[i]` at a clock edge sets pending bit i. The bit stays set after the request falls, and reads back at address 2.
- R3: Writing address 2 clears the pending bits that are 1 in the write data. If a request on the same source arrives in the same cycle, the request wins and the bit stays set.
- R4: A pending source whose enable bit (address 0, bit i) is 0 is never delivered.
- R5: While address 3 bit 0 is 0, `irq_valid` stays 0, whatever is pending.
- R6: Source i belongs to group i/3. The group's level is address 1 bits [2g+1:2g], where 3 is the highest level. Among the enabled pending sources, one at the highest level is delivered first.
- R7: When enabled pending sources share the highest level, the lowest source index is delivered first. This applies across groups as well as within one group.
- R8: On `irq_valid` and `irq_ack` in the same cycle, the offered source's pending bit clears and its level enters service. Pending requests at the same level or lower are then held back.
- R9: A pending request whose level is strictly above every level in service is offered. This allows four levels to be nested.
- R10: A pulse on `irq_reti` ends the highest level in service. Requests that were held back by that level become deliverable again.
- R11: `wake_req` is high exactly while `sleep_i` is high and some wake-capable source (bit set in `WAKE_MASK`, default sources 3, 4, 5 and 17) is both pending and enabled. The global enable does not matter for wake.
- R12: `irq_vec` is the binary index (0 to 17) of the offered source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 18 | Interrupt request lines, one per source |
| sleep_i | input | 1 | Low-power mode active |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data for `reg_addr` |
| irq_valid | output | 1 | A vector is offered to the processor |
| irq_vec | output | 5 | Index of the offered source |
| irq_ack | input | 1 | Processor takes the offered vector |
| irq_reti | input | 1 | Processor returns from the innermost handler |
| wake_req | output | 1 | Wake request while sleeping |

## Verification
A corrupted in-service record would show up at the ports either as a vector offered while a handler at the same level is still running, or as a pending request that never returns after a return pulse. A level that is stuck in service does the second. Both become visible within one cycle of the acknowledge or return that should have changed the record. A pending flag that is lost or wrongly kept shows up at the address 2 read one cycle after the edge. It can also appear as an extra or missing vector, which the expected-vector queue reports at the next delivery. Wrong arbitration shows up as a mismatch between the offered index and the next queued index on the very cycle the processor acknowledges.

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NSRC = 18,
  parameter int GSIZE = 3,
  parameter int NLVL = 4,
  parameter logic [NSRC-1:0] WAKE_MASK = 18'h20038
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            sleep_i,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_valid,
  output logic [$clog2(NSRC)-1:0] irq_vec,
  input  logic            irq_ack,
  input  logic            irq_reti,
  output logic            wake_req
);
  localparam int NGRP = NSRC / GSIZE;
  localparam int LW   = $clog2(NLVL);
  localparam int VW   = $clog2(NSRC);
  localparam int PW   = NGRP * LW;

  logic [NSRC-1:0] en, pend, cand, clr, taken;
  logic [PW-1:0]   prio;
  logic            gen;
  logic [NLVL-1:0] insvc, top, push;

  logic            found;
  logic [VW-1:0]   best;
  logic [LW-1:0]   best_lvl, cur_lvl;
  logic            has_act, take;

  assign cand = pend & en;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || prio[(i/GSIZE)*LW +: LW] > best_lvl)) begin
        found    = 1'b1;
        best     = VW'(i);
        best_lvl = prio[(i/GSIZE)*LW +: LW];
      end
    end
  end

  always_comb begin
    cur_lvl = '0;
    top     = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (insvc[l]) begin
        cur_lvl = LW'(l);
        top     = NLVL'(1) << l;
      end
    end
  end

  assign has_act   = |insvc;
  assign irq_valid = gen && found && (!has_act || best_lvl > cur_lvl);
  assign irq_vec   = best;
  assign take      = irq_valid && irq_ack;
  assign taken     = take ? (NSRC'(1) << best) : '0;
  assign push      = take ? (NLVL'(1) << best_lvl) : '0;
  assign clr       = (reg_we && reg_addr == 2'd2) ? reg_wdata : '0;
  assign wake_req  = sleep_i && |(pend & en & WAKE_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      prio  <= '0;
      gen   <= 1'b0;
      pend  <= '0;
      insvc <= '0;
    end else begin
      pend  <= (pend & ~clr & ~taken) | irq_req;
      insvc <= (insvc & ~(irq_reti ? top : '0)) | push;
      if (reg_we) begin
        case (reg_addr)
          2'd0: en   <= reg_wdata;
          2'd1: prio <= reg_wdata[PW-1:0];
          2'd3: gen  <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = en;
      2'd1: reg_rdata = NSRC'(prio);
      2'd2: reg_rdata = pend;
      default: reg_rdata = NSRC'(gen);
    endcase
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk #(
  parameter int NSRC = 18,
  parameter int NLVL = 4,
  parameter int VW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic            sleep_i,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic            irq_valid,
  input logic [VW-1:0]   irq_vec,
  input logic            irq_ack,
  input logic            irq_reti,
  input logic            wake_req,
  input logic [NSRC-1:0] pend,
  input logic [NLVL-1:0] insvc,
  input logic            gen
);
  // R2
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_we && reg_addr == 2'd2) && !(irq_valid && irq_ack)) |=> ((pend & $past(pend)) == $past(pend)));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !irq_req[irq_vec]) |=> !pend[$past(irq_vec)]);

  // R9
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !irq_reti) |=> ($countones(insvc) == $countones($past(insvc)) + 1));

  // R10
  reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !irq_ack && insvc != '0) |=> ($countones(insvc) + 1 == $countones($past(insvc))));

  // R5
  gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !irq_valid);

  // R11
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !wake_req);

  // R12
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_vec) < NSRC));
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sleep_i(sleep_i),
  .reg_we(reg_we), .reg_addr(reg_addr), .irq_valid(irq_valid),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti),
  .wake_req(wake_req), .pend(pend), .insvc(insvc), .gen(gen)
);

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] irq_req = '0;
  logic        sleep_i = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [17:0] reg_wdata = '0;
  logic [17:0] reg_rdata;
  logic        irq_valid;
  logic [4:0]  irq_vec;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;
  logic        wake_req;

  int total = 0;
  int fails = 0;
  bit auto_ack = 1'b0;
  bit done = 1'b0;
  int    expv[$];
  string expt[$];

  grp_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sleep_i(sleep_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_reti(irq_reti), .wake_req(wake_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_vec(input int v, input string tag);
    expv.push_back(v);
    expt.push_back(tag);
  endtask

  always @(negedge clk) begin
    irq_ack <= 1'b0;
    if (rst_n && auto_ack && irq_valid) begin
      if (expv.size() == 0) begin
        chk(1'b0, "R12 unexpected vector", int'(irq_vec), -1);
      end else begin
        int    v;
        string t;
        v = expv.pop_front();
        t = expt.pop_front();
        chk(int'(irq_vec) == v, t, int'(irq_vec), v);
      end
      irq_ack <= 1'b1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [17:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input logic [17:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic reti();
    @(negedge clk);
    irq_reti = 1'b1;
    @(negedge clk);
    irq_reti = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    sleep_i = 1'b1;
    idle(3);
    // R1 reset state
    chk(irq_valid == 1'b0, "R1 valid", irq_valid, 0);
    chk(wake_req == 1'b0, "R1 wake", wake_req, 0);
    rd(2'd0, 0, "R1 enable");
    rd(2'd1, 0, "R1 prio");
    rd(2'd2, 0, "R1 pending");
    rd(2'd3, 0, "R1 global");
    @(negedge clk);
    rst_n = 1'b1;
    sleep_i = 1'b0;
    auto_ack = 1'b1;
    idle(2);

    // R2 sticky pending
    pulse(18'h00020);
    idle(2);
    rd(2'd2, 32, "R2 pending sticky");

    // R3 clear and set-wins
    wr(2'd2, 18'h00020);
    rd(2'd2, 0, "R3 cleared");
    @(negedge clk);
    irq_req = 18'h00040; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 18'h00040;
    @(negedge clk);
    irq_req = '0; reg_we = 1'b0;
    rd(2'd2, 64, "R3 set wins over clear");
    wr(2'd2, 18'h3FFFF);

    // R4 source enable, R5 global enable
    wr(2'd0, 18'h3FFBF);
    pulse(18'h00040);
    wr(2'd3, 18'h1);
    idle(3);
    chk(irq_valid == 1'b0, "R4 disabled source held", irq_valid, 0);
    wr(2'd3, 18'h0);
    wr(2'd2, 18'h3FFFF);
    wr(2'd0, 18'h3FFFF);
    pulse(18'h00001);
    idle(3);
    chk(irq_valid == 1'b0, "R5 global off", irq_valid, 0);
    wr(2'd2, 18'h3FFFF);
    wr(2'd3, 18'h1);

    // R6 priority across groups, R8 hold, R10 return
    wr(2'd1, 18'h00031);
    rd(2'd1, 49, "R6 prio readback");
    expect_vec(7, "R6 higher group first");
    expect_vec(1, "R10 lower after return");
    pulse(18'h00082);
    idle(4);
    chk(irq_valid == 1'b0, "R8 lower held in service", irq_valid, 0);
    chk(expv.size() == 1, "R8 one delivered", expv.size(), 1);
    reti();
    idle(3);
    chk(expv.size() == 0, "R10 delivered after pop", expv.size(), 0);
    reti();
    idle(2);

    // R7 ties across and within groups
    wr(2'd1, 18'h00088);
    expect_vec(4, "R7 lowest index across groups");
    expect_vec(9, "R7 tie order 2nd");
    expect_vec(10, "R7 tie order 3rd");
    expect_vec(11, "R7 tie order 4th");
    pulse(18'h00E10);
    for (int k = 0; k < 4; k++) begin
      idle(3);
      chk(irq_valid == 1'b0, "R8 same level held", irq_valid, 0);
      reti();
    end
    idle(3);
    chk(expv.size() == 0, "R7 all delivered", expv.size(), 0);

    // R9 four-deep nesting
    wr(2'd1, 18'h000E4);
    expect_vec(0, "R9 level0");
    pulse(18'h00001);
    idle(2);
    expect_vec(3, "R9 level1 preempts");
    pulse(18'h00008);
    idle(2);
    expect_vec(6, "R9 level2 preempts");
    pulse(18'h00040);
    idle(2);
    expect_vec(9, "R9 level3 preempts");
    pulse(18'h00200);
    idle(2);
    chk(expv.size() == 0, "R9 nested four", expv.size(), 0);
    pulse(18'h00400);
    idle(3);
    chk(irq_valid == 1'b0, "R8 equal level at top held", irq_valid, 0);
    expect_vec(10, "R10 pop re-enables level3");
    reti();
    idle(3);
    for (int k = 0; k < 4; k++) reti();
    idle(3);
    chk(expv.size() == 0 && irq_valid == 1'b0, "R10 all popped", expv.size(), 0);
    rd(2'd2, 0, "R8 pending cleared by acks");

    // R11 wake
    wr(2'd3, 18'h0);
    sleep_i = 1'b1;
    pulse(18'h00001);
    idle(1);
    chk(wake_req == 1'b0, "R11 non-wake source", wake_req, 0);
    wr(2'd2, 18'h3FFFF);
    pulse(18'h00008);
    idle(1);
    chk(wake_req == 1'b1, "R11 wake source", wake_req, 1);
    sleep_i = 1'b0;
    #1;
    chk(wake_req == 1'b0, "R11 awake", wake_req, 0);
    sleep_i = 1'b1;
    wr(2'd0, 18'h3FFF7);
    #1;
    chk(wake_req == 1'b0, "R11 disabled wake source", wake_req, 0);
    sleep_i = 1'b0;
    idle(2);
    finish_run();
  end
endmodule